// File: doc/BRIEF.md
# Paravirtual Device Common Register File

This block is the common register window of a legacy paravirtual PCI function. The host accesses it one dword at a time through an I/O window. Each access carries a dword index and four byte enables. The block holds the feature words, the per-queue ring page frame and interrupt vector, the queue selector, the device status and the interrupt status byte. It turns doorbell writes into a one-cycle strobe that names the queue, and it signals interrupts either on a level INTx line or as vector strobes.

Any dword past the common area is forwarded to a device-specific configuration port, with the address rebased to zero. The common area is five dwords long when vectored interrupts are off and six when they are on. The device back end reports interrupt events on a request input. The block records each event in the interrupt status byte and routes it to INTx or to the assigned vector.

Top module: `pvdev_regs`

## Requirements
- R1: After rstN the guest feature word, status, interrupt status, queue select and every page frame read 0, every vector register reads 0xFFFF, and intx is low.
- R2: Dword map: 0 host features (read-only, from the hostFeat input), 1 guest features, 2 page frame of the selected queue, 3 queue size in bits 15:0 (read-only) and queue select in bits 31:16, 4 notify in bits 15:0, status in bits 23:16 and interrupt status in bits 31:24 (read-only). Writes to read-only fields have no effect.
- R3: On a write, only the byte lanes whose busBe bit is set change. Lane n covers data bits 8n+7:8n.
- R4: A queue-select write takes effect only when the resulting 16-bit value is below NQ. Page frame, queue size and queue vector accesses always use the selected queue.
- R5: The notify field reads as 0xFFFF. A write that enables lane 0 or 1 of dword 4 raises notifyStrobe for exactly the next cycle, with notifyQueue holding the written 16 bits (lanes not enabled read as zero).
- R6: Writing status 0, or writing a page frame whose merged 32-bit value is 0, resets every register to its R1 value at the next clock edge. A page-frame write that leaves nonzero bytes in the merged value does not reset.
- R7: Each irqReq sets interrupt status bit 0 for a queue event or bit 1 for a config event (irqIsCfg). With msiEn low, intx follows bit 0. A read that enables lane 3 of dword 4 returns the old byte and then clears it; a request in the same cycle survives.
- R8: With msiEn high, dword 5 holds the config vector in bits 15:0 and the selected queue's vector in bits 31:16. A written vector of NUM_VEC or more is stored as 0xFFFF.
- R9: Accesses to dword 5 or higher (msiEn low), or dword 6 or higher (msiEn high), drive devValid with devAddr = index minus the common length, and busRdata returns devRdata.
- R10: A guest-feature write whose merged value has bit BAD_BIT set stores hostFeat AND SAFE_MASK instead.
- R11: A status write that sets bit 2 (driver ready) while busMasterEn is low sets a sticky quirk flag. When busMasterEn falls and the flag is clear, status bit 2 is cleared. Reset (R6 or rstN) clears the flag.
- R12: With msiEn high, an irqReq produces vecStrobe in the next cycle carrying the config vector or the vector of irqQueue, unless that vector is 0xFFFF. intx stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| msiEn | input | 1 | Vectored interrupts enabled |
| busMasterEn | input | 1 | Bus-master enable from the command register |
| hostFeat | input | 32 | Host feature word |
| qSizes | input | NQ*16 | Size of each queue, queue q at bits 16q+15:16q |
| busValid | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | ADDR_W | Dword index of the access |
| busBe | input | 4 | Byte-lane enables |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, same cycle |
| devValid | output | 1 | Access forwarded to the device region |
| devWrite | output | 1 | Direction of the forwarded access |
| devAddr | output | ADDR_W | Rebased dword index |
| devBe | output | 4 | Forwarded byte enables |
| devWdata | output | 32 | Forwarded write data |
| devRdata | input | 32 | Device region read data |
| notifyStrobe | output | 1 | Doorbell pulse |
| notifyQueue | output | 16 | Queue index written to the doorbell |
| irqReq | input | 1 | Interrupt event from the back end |
| irqIsCfg | input | 1 | Event is a configuration change |
| irqQueue | input | clog2(NQ) | Queue of a queue event |
| intx | output | 1 | Level interrupt line |
| vecStrobe | output | 1 | Vector interrupt pulse |
| vecNum | output | 16 | Vector of the pulse |

## Verification
The hardest case to reach is the interaction between the driver-ready quirk and the bus-master enable. The stimulus first sets driver ready with bus mastering on and drops the enable, so the bit clears. It then sets driver ready with bus mastering off, which sets the flag, and toggles the enable, so the bit survives. A status-zero reset follows, and the first sequence is repeated to show the flag is gone. Partial page-frame writes whose low byte is zero check that only a fully merged zero resets. Sweeps cover every queue index, vector values on both sides of the limit, and the device-region boundary in both interrupt modes.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;
  localparam logic [15:0] NO_VECTOR = 16'hFFFF;
  localparam int DRV_READY_BIT = 2;

  // per-register strobes from the decoder to the datapath
  typedef struct packed {
    logic wrGuest;
    logic wrPfn;
    logic wrSel;
    logic wrNotify;
    logic wrStatus;
    logic rdIsr;
    logic wrCfgVec;
    logic wrQVec;
  } pvStrobes_t;

  function automatic logic [31:0] mergeLanes(input logic [31:0] oldV,
                                             input logic [31:0] newV,
                                             input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = be[i] ? newV[8*i +: 8] : oldV[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/pvdev_ctrl.sv
module pvdev_ctrl
  import pvdev_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic              msiEn,
  output pvStrobes_t        stb,
  output logic              devSel,
  output logic [ADDR_W-1:0] devOfs
);
  localparam logic [ADDR_W-1:0] D_GUEST = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] D_PFN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] D_QSEL  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] D_CTRL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] D_VEC   = ADDR_W'(5);

  logic [ADDR_W-1:0] commonLen;
  logic wr, rd, inCommon;

  always_comb begin
    commonLen = msiEn ? ADDR_W'(6) : ADDR_W'(5);
    devSel    = busValid && (busAddr >= commonLen);
    devOfs    = busAddr - commonLen;
    inCommon  = busValid && !devSel;
    wr        = inCommon && busWrite;
    rd        = inCommon && !busWrite;
    stb.wrGuest  = wr && busAddr == D_GUEST;
    stb.wrPfn    = wr && busAddr == D_PFN;
    stb.wrSel    = wr && busAddr == D_QSEL && (busBe[2] || busBe[3]);
    stb.wrNotify = wr && busAddr == D_CTRL && (busBe[0] || busBe[1]);
    stb.wrStatus = wr && busAddr == D_CTRL && busBe[2];
    stb.rdIsr    = rd && busAddr == D_CTRL && busBe[3];
    stb.wrCfgVec = wr && busAddr == D_VEC && (busBe[0] || busBe[1]);
    stb.wrQVec   = wr && busAddr == D_VEC && (busBe[2] || busBe[3]);
  end
endmodule

// File: rtl/pvdev_data.sv
module pvdev_data
  import pvdev_pkg::*;
#(
  parameter int          NQ        = 16,
  parameter int          NUM_VEC   = 8,
  parameter int          BAD_BIT   = 30,
  parameter logic [31:0] SAFE_MASK = 32'h0000_0000,
  parameter int          ADDR_W    = 8,
  localparam int         QW        = $clog2(NQ)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pvStrobes_t        stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  input  logic              msiEn,
  input  logic              busMasterEn,
  input  logic [31:0]       hostFeat,
  input  logic [NQ*16-1:0]  qSizes,
  input  logic              irqReq,
  input  logic              irqIsCfg,
  input  logic [QW-1:0]     irqQueue,
  output logic [31:0]       rdCommon,
  output logic              notifyStrobe,
  output logic [15:0]       notifyQueue,
  output logic              intx,
  output logic              vecStrobe,
  output logic [15:0]       vecNum
);
  localparam logic [15:0] VEC_LIM = 16'(NUM_VEC);
  localparam logic [15:0] Q_LIM   = 16'(NQ);

  logic [31:0] guestFeat;
  logic [31:0] pfnQ [NQ];
  logic [15:0] vecQ [NQ];
  logic [QW-1:0] qSel;
  logic [7:0]  statusR, isrR;
  logic [15:0] cfgVec;
  logic        quirk, bmPrev;

  logic [31:0] mGuest, guestNew, mPfn, mVec;
  logic [15:0] selWide, selNew, irqVec;
  logic        softRst, bmFall;

  always_comb begin
    selWide  = {{(16-QW){1'b0}}, qSel};
    mGuest   = mergeLanes(guestFeat, busWdata, busBe);
    guestNew = mGuest[BAD_BIT] ? (hostFeat & SAFE_MASK) : mGuest;
    mPfn     = mergeLanes(pfnQ[qSel], busWdata, busBe);
    mVec     = mergeLanes({vecQ[qSel], cfgVec}, busWdata, busBe);
    selNew   = {busBe[3] ? busWdata[31:24] : selWide[15:8],
                busBe[2] ? busWdata[23:16] : selWide[7:0]};
    softRst  = (stb.wrPfn && mPfn == 32'h0) ||
               (stb.wrStatus && busWdata[23:16] == 8'h0);
    bmFall   = bmPrev && !busMasterEn;
    irqVec   = irqIsCfg ? cfgVec : vecQ[irqQueue];
    intx     = !msiEn && isrR[0];
  end

  // register state; a soft reset behaves exactly like rstN
  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      guestFeat <= '0;
      qSel      <= '0;
      statusR   <= '0;
      isrR      <= '0;
      cfgVec    <= NO_VECTOR;
      quirk     <= 1'b0;
      for (int q = 0; q < NQ; q++) begin
        pfnQ[q] <= '0;
        vecQ[q] <= NO_VECTOR;
      end
    end else begin
      if (stb.wrGuest) guestFeat <= guestNew;
      if (stb.wrPfn) pfnQ[qSel] <= mPfn;
      if (stb.wrSel && selNew < Q_LIM) qSel <= selNew[QW-1:0];
      if (stb.wrStatus) statusR <= busWdata[23:16];
      else if (bmFall && !quirk) statusR[DRV_READY_BIT] <= 1'b0;
      if (stb.wrStatus && busWdata[16+DRV_READY_BIT] && !busMasterEn) quirk <= 1'b1;
      if (stb.wrCfgVec) cfgVec <= (mVec[15:0] < VEC_LIM) ? mVec[15:0] : NO_VECTOR;
      if (stb.wrQVec) vecQ[qSel] <= (mVec[31:16] < VEC_LIM) ? mVec[31:16] : NO_VECTOR;
      if (stb.rdIsr) isrR <= '0;
      if (irqReq) isrR[irqIsCfg ? 1 : 0] <= 1'b1;
    end
  end

  // pulse outputs and edge tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      notifyStrobe <= 1'b0;
      notifyQueue  <= '0;
      vecStrobe    <= 1'b0;
      vecNum       <= NO_VECTOR;
      bmPrev       <= 1'b0;
    end else begin
      notifyStrobe <= stb.wrNotify;
      notifyQueue  <= {busBe[1] ? busWdata[15:8] : 8'h0, busBe[0] ? busWdata[7:0] : 8'h0};
      vecStrobe    <= irqReq && msiEn && irqVec != NO_VECTOR;
      vecNum       <= irqVec;
      bmPrev       <= busMasterEn;
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_W'(0): rdCommon = hostFeat;
      ADDR_W'(1): rdCommon = guestFeat;
      ADDR_W'(2): rdCommon = pfnQ[qSel];
      ADDR_W'(3): rdCommon = {selWide, qSizes[qSel*16 +: 16]};
      ADDR_W'(4): rdCommon = {isrR, statusR, 16'hFFFF};
      ADDR_W'(5): rdCommon = {vecQ[qSel], cfgVec};
      default:    rdCommon = 32'hFFFF_FFFF;
    endcase
  end
endmodule

// File: rtl/pvdev_regs.sv
module pvdev_regs
  import pvdev_pkg::*;
#(
  parameter int          NQ        = 16,
  parameter int          NUM_VEC   = 8,
  parameter int          BAD_BIT   = 30,
  parameter logic [31:0] SAFE_MASK = 32'h0000_0000,
  parameter int          ADDR_W    = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   msiEn,
  input  logic                   busMasterEn,
  input  logic [31:0]            hostFeat,
  input  logic [NQ*16-1:0]       qSizes,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [3:0]             busBe,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  output logic                   devValid,
  output logic                   devWrite,
  output logic [ADDR_W-1:0]      devAddr,
  output logic [3:0]             devBe,
  output logic [31:0]            devWdata,
  input  logic [31:0]            devRdata,
  output logic                   notifyStrobe,
  output logic [15:0]            notifyQueue,
  input  logic                   irqReq,
  input  logic                   irqIsCfg,
  input  logic [$clog2(NQ)-1:0]  irqQueue,
  output logic                   intx,
  output logic                   vecStrobe,
  output logic [15:0]            vecNum
);
  pvStrobes_t stb;
  logic [31:0] rdCommon;

  pvdev_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .busBe(busBe),
    .msiEn(msiEn), .stb(stb), .devSel(devValid), .devOfs(devAddr)
  );

  pvdev_data #(.NQ(NQ), .NUM_VEC(NUM_VEC), .BAD_BIT(BAD_BIT),
               .SAFE_MASK(SAFE_MASK), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busBe(busBe),
    .busWdata(busWdata), .msiEn(msiEn), .busMasterEn(busMasterEn),
    .hostFeat(hostFeat), .qSizes(qSizes), .irqReq(irqReq), .irqIsCfg(irqIsCfg),
    .irqQueue(irqQueue), .rdCommon(rdCommon), .notifyStrobe(notifyStrobe),
    .notifyQueue(notifyQueue), .intx(intx), .vecStrobe(vecStrobe), .vecNum(vecNum)
  );

  assign devWrite = busWrite;
  assign devBe    = busBe;
  assign devWdata = busWdata;
  assign busRdata = devValid ? devRdata : rdCommon;
endmodule

// File: rtl/pvdev_regs_chk.sv
module pvdev_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              msiEn,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [3:0]        busBe,
  input logic [31:0]       busWdata,
  input logic              devValid,
  input logic              notifyStrobe,
  input logic [15:0]       notifyQueue,
  input logic              irqReq,
  input logic              intx,
  input logic              vecStrobe
);
  // R5: a doorbell write yields the strobe with its value next cycle
  a_r5_notify_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == ADDR_W'(4) && busBe[0] && !devValid)
      |=> (notifyStrobe && notifyQueue[7:0] == $past(busWdata[7:0])));

  // R5: no strobe without a write in the previous cycle
  a_r5_notify_cause: assert property (@(posedge clk) disable iff (!rstN)
    notifyStrobe |-> $past(busValid && busWrite));

  // R7: reading the interrupt status drops the line
  a_r7_isr_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == ADDR_W'(4) && busBe[3] && !irqReq)
      |=> !intx);

  // R7: the line only rises after an event or a mode change
  a_r7_intx_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intx) |-> ($past(irqReq) || $fell(msiEn)));

  // R12: a vector pulse needs a request in vectored mode
  a_r12_vec_cause: assert property (@(posedge clk) disable iff (!rstN)
    vecStrobe |-> $past(irqReq && msiEn));

  // R9: the device region never covers the first five dwords
  a_r9_dev_range: assert property (@(posedge clk) disable iff (!rstN)
    devValid |-> busAddr >= ADDR_W'(5));
endmodule

bind pvdev_regs pvdev_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .msiEn(msiEn), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busBe(busBe), .busWdata(busWdata), .devValid(devValid),
  .notifyStrobe(notifyStrobe), .notifyQueue(notifyQueue), .irqReq(irqReq),
  .intx(intx), .vecStrobe(vecStrobe)
);

// File: tb/tb_pvdev_regs.sv
module tb_pvdev_regs;
  localparam int NQ = 4;
  localparam int NUM_VEC = 8;
  localparam logic [31:0] SAFE = 32'h0000_F0F0;
  localparam logic [31:0] HOST = 32'h4000_A5A5;

  logic clk = 1'b0, rstN = 1'b0;
  logic msiEn = 1'b0, busMasterEn = 1'b1;
  logic [NQ*16-1:0] qSizes;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [3:0] busBe = '0;
  logic [31:0] busWdata = '0, busRdata, devRdata, devWdata;
  logic devValid, devWrite;
  logic [7:0] devAddr;
  logic [3:0] devBe;
  logic notifyStrobe, intx, vecStrobe;
  logic [15:0] notifyQueue, vecNum;
  logic irqReq = 1'b0, irqIsCfg = 1'b0;
  logic [1:0] irqQueue = '0;

  int nChecks = 0, nErr = 0;
  logic capDev;
  logic [7:0] capDevAddr;

  always #4 clk = ~clk;

  for (genvar q = 0; q < NQ; q++) begin : g_sz
    assign qSizes[q*16 +: 16] = 16'h40 + 16'(q * 16);
  end
  assign devRdata = 32'hD0D0_0000 | {24'h0, devAddr};

  pvdev_regs #(.NQ(NQ), .NUM_VEC(NUM_VEC), .BAD_BIT(30), .SAFE_MASK(SAFE), .ADDR_W(8)) dut (
    .clk(clk), .rstN(rstN), .msiEn(msiEn), .busMasterEn(busMasterEn), .hostFeat(HOST),
    .qSizes(qSizes), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .devValid(devValid),
    .devWrite(devWrite), .devAddr(devAddr), .devBe(devBe), .devWdata(devWdata),
    .devRdata(devRdata), .notifyStrobe(notifyStrobe), .notifyQueue(notifyQueue),
    .irqReq(irqReq), .irqIsCfg(irqIsCfg), .irqQueue(irqQueue), .intx(intx),
    .vecStrobe(vecStrobe), .vecNum(vecNum)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busBe = be; busWdata = d;
    #1 capDev = devValid; capDevAddr = devAddr;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a; busBe = be;
    #1 d = busRdata; capDev = devValid; capDevAddr = devAddr;
    @(negedge clk);
    busValid = 0;
  endtask

  task automatic irq(input logic isCfg, input logic [1:0] q);
    @(negedge clk);
    irqReq = 1; irqIsCfg = isCfg; irqQueue = q;
    @(negedge clk);
    irqReq = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [15:0] e16;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1 reset state
    rd(1, 4'hF, d); chk("R1 guest", d, 0);
    rd(4, 4'b0111, d); chk("R1 status/isr", d, 32'h0000_FFFF);
    rd(3, 4'hF, d); chk("R1 qsel", d, 32'h0000_0040);
    rd(2, 4'hF, d); chk("R1 pfn", d, 0);
    chk("R1 intx", {31'h0, intx}, 0);
    msiEn = 1;
    rd(5, 4'hF, d); chk("R1 vectors", d, 32'hFFFF_FFFF);
    msiEn = 0;

    // R2 read-only fields
    rd(0, 4'hF, d); chk("R2 host", d, HOST);
    wr(0, 4'hF, 32'h1234_5678);
    rd(0, 4'hF, d); chk("R2 host ro", d, HOST);
    wr(3, 4'b0011, 32'h0000_BEEF);
    rd(3, 4'hF, d); chk("R2 qsize ro", d, 32'h0000_0040);

    // R3 byte lanes
    wr(1, 4'hF, 32'hAABB_CCDD);
    wr(1, 4'b0101, 32'h1122_3344);
    rd(1, 4'hF, d); chk("R3 lanes", d, 32'hAA22_CC44);

    // R10 bad feature bit
    wr(1, 4'hF, 32'h4000_0001);
    rd(1, 4'hF, d); chk("R10 bad", d, HOST & SAFE);
    wr(1, 4'hF, 32'h0000_0001);
    rd(1, 4'hF, d); chk("R10 good", d, 32'h1);

    // R4 per-queue sweep
    for (int q = 0; q < NQ; q++) begin
      wr(3, 4'b1100, q << 16);
      wr(2, 4'hF, 32'h100 + q * 17 + 1);
    end
    for (int q = 0; q < NQ; q++) begin
      wr(3, 4'b1100, q << 16);
      rd(2, 4'hF, d); chk("R4 pfn", d, 32'h100 + q * 17 + 1);
      rd(3, 4'hF, d); chk("R4 size/sel", d, (q << 16) | (32'h40 + q * 16));
    end
    wr(3, 4'b1100, NQ << 16);
    rd(3, 4'hF, d); chk("R4 sel limit", d[31:16], NQ - 1);
    wr(3, 4'b1100, 32'hFFFF_0000);
    rd(3, 4'hF, d); chk("R4 sel ffff", d[31:16], NQ - 1);
    wr(3, 4'b0100, 32'h0001_0000);
    rd(3, 4'hF, d); chk("R4 sel lane", d[31:16], 1);

    // R6 partial page-frame write leaving nonzero bytes: no reset
    wr(2, 4'b0001, 32'h0);
    rd(2, 4'hF, d); chk("R6 partial pfn", d, 32'h100);
    rd(1, 4'hF, d); chk("R6 no reset", d, 32'h1);

    // R5 doorbell
    for (int v = 0; v < NQ + 1; v++) begin
      e16 = (v == NQ) ? 16'h1234 : 16'(v);
      wr(4, 4'b0011, {16'h0, e16});
      chk("R5 strobe", {31'h0, notifyStrobe}, 1);
      chk("R5 queue", {16'h0, notifyQueue}, {16'h0, e16});
      @(negedge clk);
      chk("R5 one cycle", {31'h0, notifyStrobe}, 0);
    end
    rd(4, 4'b0011, d); chk("R5 reads ones", {16'h0, d[15:0]}, 32'hFFFF);

    // R7 interrupt status and INTx
    irq(0, 2);
    chk("R7 intx set", {31'h0, intx}, 1);
    rd(4, 4'b1000, d); chk("R7 isr old", {24'h0, d[31:24]}, 1);
    chk("R7 intx clr", {31'h0, intx}, 0);
    rd(4, 4'b1000, d); chk("R7 isr clr", {24'h0, d[31:24]}, 0);
    irq(1, 0);
    chk("R7 cfg no intx", {31'h0, intx}, 0);
    rd(4, 4'b1000, d); chk("R7 cfg bit", {24'h0, d[31:24]}, 2);

    // R11 driver-ready quirk
    wr(4, 4'b0100, 32'h0007_0000);
    @(negedge clk) busMasterEn = 0;
    @(negedge clk);
    rd(4, 4'b0100, d); chk("R11 ready cleared", {24'h0, d[23:16]}, 3);
    wr(4, 4'b0100, 32'h0007_0000);
    @(negedge clk) busMasterEn = 1;
    @(negedge clk) busMasterEn = 0;
    @(negedge clk);
    rd(4, 4'b0100, d); chk("R11 quirk keeps", {24'h0, d[23:16]}, 7);

    // R6 status-zero reset
    wr(4, 4'b0100, 32'h0);
    rd(1, 4'hF, d); chk("R6 status rst guest", d, 0);
    rd(3, 4'hF, d); chk("R6 status rst sel", d, 32'h40);
    rd(2, 4'hF, d); chk("R6 status rst pfn", d, 0);
    @(negedge clk) busMasterEn = 1;
    wr(4, 4'b0100, 32'h0005_0000);
    @(negedge clk) busMasterEn = 0;
    @(negedge clk);
    rd(4, 4'b0100, d); chk("R11 quirk reset", {24'h0, d[23:16]}, 1);
    @(negedge clk) busMasterEn = 1;

    // R6 page-frame-zero reset
    wr(1, 4'hF, 32'h55);
    wr(2, 4'hF, 32'h0);
    rd(1, 4'hF, d); chk("R6 pfn rst guest", d, 0);
    rd(4, 4'b0100, d); chk("R6 pfn rst status", {24'h0, d[23:16]}, 0);

    // R8 vector registers
    msiEn = 1;
    for (int v = 0; v < NUM_VEC + 2; v++) begin
      wr(5, 4'b0011, v);
      rd(5, 4'hF, d);
      chk("R8 cfg vec", {16'h0, d[15:0]}, (v < NUM_VEC) ? v : 32'hFFFF);
    end
    for (int q = 0; q < NQ; q++) begin
      wr(3, 4'b1100, q << 16);
      wr(5, 4'b1100, (q * 3) << 16);
    end
    for (int q = 0; q < NQ; q++) begin
      wr(3, 4'b1100, q << 16);
      rd(5, 4'hF, d);
      chk("R8 queue vec", {16'h0, d[31:16]}, (q * 3 < NUM_VEC) ? q * 3 : 32'hFFFF);
    end

    // R12 vector delivery
    wr(5, 4'b0011, 7);
    irq(0, 1);
    chk("R12 strobe", {31'h0, vecStrobe}, 1);
    chk("R12 vec", {16'h0, vecNum}, 3);
    chk("R12 no intx", {31'h0, intx}, 0);
    irq(0, 3);
    chk("R12 no vector", {31'h0, vecStrobe}, 0);
    irq(1, 0);
    chk("R12 cfg strobe", {31'h0, vecStrobe}, 1);
    chk("R12 cfg vec", {16'h0, vecNum}, 7);
    wr(4, 4'b0100, 32'h0);
    rd(5, 4'hF, d); chk("R1 vectors after reset", d, 32'hFFFF_FFFF);

    // R9 device region in both modes
    rd(6, 4'hF, d);
    chk("R9 msi dev", {31'h0, capDev}, 1);
    chk("R9 msi addr", {24'h0, capDevAddr}, 0);
    chk("R9 rdata", d, 32'hD0D0_0000);
    rd(9, 4'hF, d); chk("R9 msi addr3", {24'h0, capDevAddr}, 3);
    rd(5, 4'hF, d); chk("R9 msi common", {31'h0, capDev}, 0);
    msiEn = 0;
    rd(5, 4'hF, d);
    chk("R9 plain dev", {31'h0, capDev}, 1);
    chk("R9 plain addr", {24'h0, capDevAddr}, 0);
    wr(7, 4'hF, 32'h1);
    chk("R9 write addr", {24'h0, capDevAddr}, 2);
    rd(4, 4'hF, d); chk("R9 common", {31'h0, capDev}, 0);

    summary();
  end
endmodule